// File: doc/BRIEF.md
# Synchronous Slave FIFO Stream Writer

This block is the FPGA-side master for the synchronous slave FIFO of an external USB controller that has been set up for an IN endpoint. It forwards its own clock to the controller as the interface clock. It holds the endpoint-select address on the IN endpoint, keeps chip select asserted and keeps the FIFO's output driver disabled. While a stream-enable input is high, it pushes an incrementing byte pattern into the FIFO. Every control pin and flag on this interface is active low.

Each write strobe is gated by a registered copy of the full flag, so a full endpoint never loses a byte and the pattern has no gaps. A per-packet byte position is tracked. Full packets are committed by the controller itself. A rising edge on a request input produces a one-cycle packet-end pulse, which commits a partly filled packet.

Top module: `sfifo_stream_writer`

## Requirements
- R1: `ifc_clk_o` follows `clk_i`. `ep_sel_o` holds the value 2'b11. `cs_no` is held low and `oe_no` is held high at all times.
- R2: A low `rst_ni` acts at once, without waiting for a clock edge. It forces `wr_no` and `pkt_end_no` high, sets `data_o` to zero, and clears the pattern, the packet position and the request edge detector.
- R3: The full flag `full_ni` (low = full) is registered once. `wr_no` goes low after an edge only if the registered flag read not full and `stream_en_i` was high at that edge. Writes therefore begin at the second edge after the flag is released and stop at the second edge after it is asserted.
- R4: A write puts the pattern byte on `data_o[7:0]` and zero on `data_o[15:8]`. The first write after reset carries 0x00.
- R5: The pattern advances by one only when a write happens, and wraps from 0xFF to 0x00. While `wr_no` is high, `data_o` holds the last written value.
- R6: A rising edge on `short_req_i` drives `pkt_end_no` low for exactly one cycle, starting after the next clock edge. `wr_no` is high in that cycle, and the deferred write does not consume a pattern value. A request held high yields one pulse only.
- R7: The packet position counts writes modulo 512. Reaching 512 wraps the position to zero with no packet-end pulse, because the controller commits full packets itself. A packet-end pulse also returns the position to zero.
- R8: A request edge that arrives while the packet position is zero is dropped, and no zero-length packet is sent.
- R9: After reset, no write is made until the registered full flag has read not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, also forwarded as the interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_ni | input | 1 | FIFO full flag of the selected endpoint, active low |
| empty_ni | input | 1 | FIFO empty flag of the selected endpoint, active low |
| stream_en_i | input | 1 | Pattern data is available for writing |
| short_req_i | input | 1 | Rising edge requests a short-packet commit |
| ifc_clk_o | output | 1 | Interface clock to the controller |
| ep_sel_o | output | 2 | Endpoint FIFO address |
| cs_no | output | 1 | Chip select, active low |
| oe_no | output | 1 | FIFO output enable, active low |
| wr_no | output | 1 | Write strobe, active low |
| pkt_end_no | output | 1 | Packet end, active low |
| data_o | output | 16 | FIFO data bus; payload in the low byte |

## Verification
A wrong pattern register shows up as a skipped or repeated byte on the very next write. The scoreboard compares every written byte against its own counter, so such an error is caught within one cycle. A wrong packet position only becomes visible when a short-packet request arrives: a pulse that should have been dropped, or a missing pulse, shows on `pkt_end_no` one edge after the request. For this reason the bench places requests exactly at packet position zero, both after a commit and after 512 writes. An off-by-one in the flag register moves the first and last write by one cycle, so these edges are checked on the exact cycle.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

   typedef enum logic [1:0] {
      SFW_IDLE   = 2'd0,
      SFW_WRITE  = 2'd1,
      SFW_COMMIT = 2'd2
   } sfw_act_e;

   function automatic int unsigned sfw_cnt_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   function automatic bit sfw_is_pow2(input int unsigned val);
      return (val != 0) && ((val & (val - 1)) == 0);
   endfunction

endpackage

// File: rtl/sfw_flag_sync.sv
module sfw_flag_sync #(
   parameter int unsigned STAGES = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic full_ni,
   input  logic empty_ni,
   output logic room_o,
   output logic empty_no
);

   initial begin
      if (STAGES < 1 || STAGES > 4)
         $fatal(1, "sfw_flag_sync: STAGES must be 1..4");
   end

   logic [STAGES-1:0] full_sh;
   logic [STAGES-1:0] empty_sh;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_sh  <= '0;
         empty_sh <= '1;
      end else begin
         full_sh[0]  <= full_ni;
         empty_sh[0] <= empty_ni;
      end
   end

   generate
      if (STAGES > 1) begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               full_sh[STAGES-1:1]  <= '0;
               empty_sh[STAGES-1:1] <= '1;
            end else begin
               full_sh[STAGES-1:1]  <= full_sh[STAGES-2:0];
               empty_sh[STAGES-1:1] <= empty_sh[STAGES-2:0];
            end
         end
      end
   endgenerate

   assign room_o   = full_sh[STAGES-1];
   assign empty_no = empty_sh[STAGES-1];

   // R3: full and empty are never reported together by a sane controller
   p_flags_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (room_o || empty_no));

endmodule

// File: rtl/sfw_pattern_gen.sv
module sfw_pattern_gen #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PAT_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   output logic [DATA_W-1:0] data_o
);

   initial begin
      if (PAT_W < 1 || PAT_W > DATA_W)
         $fatal(1, "sfw_pattern_gen: PAT_W must be 1..DATA_W");
   end

   logic [PAT_W-1:0]  pat_q;
   logic [DATA_W-1:0] bus_next;
   logic [DATA_W-1:0] data_q;

   generate
      if (DATA_W > PAT_W) begin : g_pad
         assign bus_next = {{(DATA_W-PAT_W){1'b0}}, pat_q};
      end else begin : g_full
         assign bus_next = pat_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pat_q  <= '0;
         data_q <= '0;
      end else if (adv_i) begin
         pat_q  <= pat_q + 1'b1;
         data_q <= bus_next;
      end
   end

   assign data_o = data_q;

   // R5: the staged pattern value only moves when a write consumes it
   p_pat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(adv_i) |-> $stable(pat_q));

endmodule

// File: rtl/sfw_pkt_counter.sv
module sfw_pkt_counter
   import sfw_pkg::*;
#(
   parameter int unsigned PKT_BYTES = 512
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic inc_i,
   input  logic clr_i,
   output logic at_zero_o
);

   localparam int unsigned CNT_W = sfw_cnt_width(PKT_BYTES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_BYTES - 1);

   initial begin
      if (PKT_BYTES < 2)
         $fatal(1, "sfw_pkt_counter: PKT_BYTES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (sfw_is_pow2(PKT_BYTES)) begin : g_natural_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end else begin : g_compare_wrap
         assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (inc_i)
         cnt_q <= cnt_inc;
   end

   assign at_zero_o = (cnt_q == '0);

   // R7: the position never leaves the packet
   p_cnt_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);

   // R7: a commit always restarts the packet
   p_clr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> at_zero_o);

endmodule

// File: rtl/sfw_write_ctrl.sv
module sfw_write_ctrl
   import sfw_pkg::*;
#(
   parameter bit ZLP_EN = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic room_i,
   input  logic en_i,
   input  logic req_i,
   input  logic cnt_zero_i,
   output logic adv_o,
   output logic clr_o,
   output logic wr_no,
   output logic pkt_end_no
);

   sfw_act_e act;
   logic     req_q;
   logic     req_edge;
   logic     commit_ok;
   logic     wr_q;
   logic     pe_q;

   assign req_edge = req_i & ~req_q;

   generate
      if (ZLP_EN) begin : g_zlp
         assign commit_ok = req_edge;
      end else begin : g_no_zlp
         assign commit_ok = req_edge & ~cnt_zero_i;
      end
   endgenerate

   always_comb begin
      act = SFW_IDLE;
      if (commit_ok)
         act = SFW_COMMIT;
      else if (room_i && en_i)
         act = SFW_WRITE;
   end

   assign adv_o = (act == SFW_WRITE);
   assign clr_o = (act == SFW_COMMIT);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q <= 1'b0;
         wr_q  <= 1'b1;
         pe_q  <= 1'b1;
      end else begin
         req_q <= req_i;
         wr_q  <= (act != SFW_WRITE);
         pe_q  <= (act != SFW_COMMIT);
      end
   end

   assign wr_no      = wr_q;
   assign pkt_end_no = pe_q;

   // R6: packet end is a single-cycle pulse
   p_end_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pkt_end_no |=> pkt_end_no);

   // R6: no data strobe in the packet-end cycle
   p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(~pkt_end_no && ~wr_no));

   // R6: a held request produces no second pulse
   p_held_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(req_i) && req_i) |=> pkt_end_no);

endmodule

// File: rtl/sfifo_stream_writer.sv
module sfifo_stream_writer
   import sfw_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned PAT_W       = 8,
   parameter int unsigned PKT_BYTES   = 512,
   parameter int unsigned FLAG_STAGES = 1,
   parameter logic [1:0]  EP_ADDR     = 2'b11,
   parameter bit          ZLP_EN      = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              full_ni,
   input  logic              empty_ni,
   input  logic              stream_en_i,
   input  logic              short_req_i,
   output logic              ifc_clk_o,
   output logic [1:0]        ep_sel_o,
   output logic              cs_no,
   output logic              oe_no,
   output logic              wr_no,
   output logic              pkt_end_no,
   output logic [DATA_W-1:0] data_o
);

   initial begin
      if (DATA_W < 8)
         $fatal(1, "sfifo_stream_writer: DATA_W must be at least 8");
   end

   logic room;
   logic empty_n;
   logic adv;
   logic clr;
   logic cnt_zero;

   assign ifc_clk_o = clk_i;
   assign ep_sel_o  = EP_ADDR;
   assign cs_no     = 1'b0;
   assign oe_no     = 1'b1;

   sfw_flag_sync #(
      .STAGES (FLAG_STAGES)
   ) u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .full_ni  (full_ni),
      .empty_ni (empty_ni),
      .room_o   (room),
      .empty_no (empty_n)
   );

   sfw_write_ctrl #(
      .ZLP_EN (ZLP_EN)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .room_i     (room),
      .en_i       (stream_en_i),
      .req_i      (short_req_i),
      .cnt_zero_i (cnt_zero),
      .adv_o      (adv),
      .clr_o      (clr),
      .wr_no      (wr_no),
      .pkt_end_no (pkt_end_no)
   );

   sfw_pattern_gen #(
      .DATA_W (DATA_W),
      .PAT_W  (PAT_W)
   ) u_pat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv),
      .data_o (data_o)
   );

   sfw_pkt_counter #(
      .PKT_BYTES (PKT_BYTES)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (adv),
      .clr_i     (clr),
      .at_zero_o (cnt_zero)
   );

   // R3: every strobe follows a registered not-full reading
   p_write_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_no |-> $past(room));

   // R5: back-to-back writes carry consecutive pattern values
   p_pattern_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!wr_no) && !wr_no) |-> (data_o[PAT_W-1:0] == $past(data_o[PAT_W-1:0]) + 1'b1));

   // R5: the bus holds between writes
   p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_no |-> $stable(data_o));

   // R4: the bits above the pattern stay zero
   p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_o >> PAT_W) == '0);

   // R8: without zero-length packets, a pulse needs a partly filled packet
   p_commit_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pkt_end_no && !ZLP_EN) |-> $past(!cnt_zero));

   // R1: the FIFO output driver stays off
   p_static_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_no && !cs_no && ep_sel_o == EP_ADDR && empty_n | !empty_n));

endmodule

// File: tb/sfifo_stream_writer_tb_top.sv
`timescale 1ns/1ps
module sfifo_stream_writer_tb_top;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        full_ni = 1'b0;
   logic        empty_ni = 1'b1;
   logic        stream_en_i = 1'b0;
   logic        short_req_i = 1'b0;
   logic        ifc_clk_o;
   logic [1:0]  ep_sel_o;
   logic        cs_no;
   logic        oe_no;
   logic        wr_no;
   logic        pkt_end_no;
   logic [15:0] data_o;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;
   logic [7:0] exp_pat = 8'h00;
   logic [7:0] obs_q[$];

   always #10 clk = ~clk;

   sfifo_stream_writer dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .full_ni     (full_ni),
      .empty_ni    (empty_ni),
      .stream_en_i (stream_en_i),
      .short_req_i (short_req_i),
      .ifc_clk_o   (ifc_clk_o),
      .ep_sel_o    (ep_sel_o),
      .cs_no       (cs_no),
      .oe_no       (oe_no),
      .wr_no       (wr_no),
      .pkt_end_no  (pkt_end_no),
      .data_o      (data_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: collect written bytes, count packet-end pulses
   always @(negedge clk) begin
      if (rst_ni) begin
         if (!wr_no) obs_q.push_back(data_o[7:0]);
         if (!pkt_end_no) begin
            pulses++;
            chk("R6 no strobe in packet-end cycle", {31'd0, wr_no}, 32'd1);
         end
      end
   end

   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic drain(input string req);
      while (obs_q.size() > 0) begin
         logic [7:0] b;
         b = obs_q.pop_front();
         chk(req, {24'd0, b}, {24'd0, exp_pat});
         exp_pat = exp_pat + 8'd1;
      end
   endtask

   task automatic do_reset();
      @(posedge clk);
      #2;
      rst_ni = 1'b0;
      stream_en_i = 1'b0;
      short_req_i = 1'b0;
      full_ni = 1'b0;
      #1;
      drain("R5 scoreboard before reset");
      exp_pat = 8'h00;
      cyc(2);
      rst_ni = 1'b1;
   endtask

   task automatic release_flag();
      full_ni = 1'b1;
      cyc(2);
   endtask

   initial begin
      int p0;
      cyc(3);
      // R2 reset state
      chk("R2 wr_no in reset", {31'd0, wr_no}, 32'd1);
      chk("R2 pkt_end_no in reset", {31'd0, pkt_end_no}, 32'd1);
      chk("R2 data in reset", {16'd0, data_o}, 32'd0);
      // R1 static pins and clock forwarding
      chk("R1 ep_sel", {30'd0, ep_sel_o}, 32'd3);
      chk("R1 cs_no", {31'd0, cs_no}, 32'd0);
      chk("R1 oe_no", {31'd0, oe_no}, 32'd1);
      chk("R1 ifc_clk high phase", {31'd0, ifc_clk_o}, 32'd1);
      #10;
      chk("R1 ifc_clk low phase", {31'd0, ifc_clk_o}, 32'd0);
      cyc(1);
      rst_ni = 1'b1;

      // R9 full after reset: no writes
      stream_en_i = 1'b1;
      cyc(4);
      chk("R9 hold while full", {31'd0, wr_no}, 32'd1);

      // R3 release: writes begin at second edge
      full_ni = 1'b1;
      cyc(1);
      chk("R3 no write one edge after release", {31'd0, wr_no}, 32'd1);
      cyc(1);
      chk("R3 write two edges after release", {31'd0, wr_no}, 32'd0);
      chk("R4 first byte zero", {16'd0, data_o}, 32'd0);
      cyc(299);
      chk("R4 upper byte zero", {24'd0, data_o[15:8]}, 32'd0);
      drain("R5 increment and wrap");

      // R3 back-pressure
      full_ni = 1'b0;
      cyc(1);
      chk("R3 in-flight write", {31'd0, wr_no}, 32'd0);
      cyc(1);
      chk("R3 stop on full", {31'd0, wr_no}, 32'd1);
      p0 = data_o;
      cyc(3);
      chk("R5 stall holds data", {16'd0, data_o}, p0);
      chk("R3 still stopped", {31'd0, wr_no}, 32'd1);
      full_ni = 1'b1;
      cyc(2);
      chk("R3 resume write", {31'd0, wr_no}, 32'd0);
      chk("R5 resume next value", {16'd0, data_o}, (p0 + 1) & 32'hFF);
      drain("R5 after stall");

      // R3 enable low stops writes
      stream_en_i = 1'b0;
      cyc(1);
      chk("R3 no write when disabled", {31'd0, wr_no}, 32'd1);
      p0 = data_o;

      // R6 commit while streaming
      p0 = pulses;
      stream_en_i = 1'b1;
      short_req_i = 1'b1;
      cyc(1);
      chk("R6 pulse low", {31'd0, pkt_end_no}, 32'd0);
      chk("R6 strobe high in pulse", {31'd0, wr_no}, 32'd1);
      cyc(1);
      chk("R6 pulse one cycle", {31'd0, pkt_end_no}, 32'd1);
      chk("R6 write resumes", {31'd0, wr_no}, 32'd0);
      cyc(3);
      chk("R6 held request single pulse", pulses - p0, 32'd1);
      stream_en_i = 1'b0;
      short_req_i = 1'b0;
      cyc(1);
      short_req_i = 1'b1;
      cyc(1);
      chk("R6 second commit", {31'd0, pkt_end_no}, 32'd0);
      short_req_i = 1'b0;
      cyc(1);
      // R8 request at position zero after commit
      short_req_i = 1'b1;
      cyc(1);
      chk("R8 no pulse at zero after commit", {31'd0, pkt_end_no}, 32'd1);
      cyc(1);
      short_req_i = 1'b0;
      drain("R5 around commits");

      // R7 full packet wrap
      do_reset();
      release_flag();
      p0 = pulses;
      stream_en_i = 1'b1;
      cyc(512);
      stream_en_i = 1'b0;
      cyc(1);
      chk("R7 no pulse at packet wrap", pulses - p0, 32'd0);
      short_req_i = 1'b1;
      cyc(1);
      chk("R8 no pulse after 512 writes", {31'd0, pkt_end_no}, 32'd1);
      cyc(1);
      short_req_i = 1'b0;
      stream_en_i = 1'b1;
      cyc(3);
      stream_en_i = 1'b0;
      cyc(1);
      short_req_i = 1'b1;
      cyc(1);
      chk("R7 pulse after three bytes", {31'd0, pkt_end_no}, 32'd1 - 32'd1);
      short_req_i = 1'b0;
      cyc(1);
      drain("R7 packet data");

      // R2 asynchronous reset mid-stream
      stream_en_i = 1'b1;
      cyc(5);
      rst_ni = 1'b0;
      #1;
      chk("R2 async wr_no", {31'd0, wr_no}, 32'd1);
      chk("R2 async data", {16'd0, data_o}, 32'd0);
      chk("R2 async pkt_end_no", {31'd0, pkt_end_no}, 32'd1);
      drain("R5 before async reset");
      exp_pat = 8'h00;
      full_ni = 1'b1;
      cyc(2);
      rst_ni = 1'b1;
      cyc(2);
      chk("R9 first write after reset", {31'd0, wr_no}, 32'd0);
      chk("R2 pattern restarts", {16'd0, data_o}, 32'd0);
      stream_en_i = 1'b0;
      cyc(2);
      drain("R2 restart sequence");

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule